// File: doc/BRIEF.md
# Reed-Solomon Decoder Timing Controller

This block sequences a byte-serial Reed-Solomon decoder. During a synchronous active-low reset it samples a 5-bit correction-flag limit, a status-select bit and two latency-select bits. After reset it watches the `data_phase` input. The first framed block is high for K symbol clocks and low for R symbol clocks. The controller counts both phases and holds K, R and N = K + R until the next reset.

From N, R and the latched latency selection, the block computes the fixed decode latency and the smallest block length the selected mode accepts. It raises a parameter-error flag when the learned code cannot be used. On the input side it emits one-cycle strobes for block start and parity start. On the output side it replays each block start after the computed latency. The output-side data-ready is high for the K data symbols. The end-of-block strobe pulses on the last of the N output symbols. Symbol arithmetic and the symbol delay memory sit outside this block. The block only produces the timing that those parts follow.

Top module: `rsd_timing_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `params_valid_o`, `param_err_o`, `latency_o`, `k_o`, `r_o`, `n_o`, both input strobes and both output strobes are all zero.
- R2: `flag_lim_o` and `stat_sel_o` show the `flag_lim_i` and `stat_sel_i` values sampled in the last reset cycle. Changes to those inputs while `rst_n` is high have no effect on them.
- R3: The first `data_phase` rising edge after reset starts learning. K is the number of high cycles and R is the number of low cycles before the next rising edge. In the cycle after that next rising edge is sampled, `k_o`=K, `r_o`=R, `n_o`=K+R and `params_valid_o`=1.
- R4: Once valid, K, R and N hold until the next reset, even when later blocks have a different data length.
- R5: After reset, each sampled rising edge of `data_phase` gives `blk_start_o` high for exactly the next cycle. Each sampled falling edge gives `par_start_o` high for exactly the next cycle.
- R6: When both latency selects were low at reset, `latency_o` = 2N+5R+33 and the minimum block length is 5R+15.
- R7: When `lat_sel_a` was high and `lat_sel_b` low at reset, `latency_o` = 2N+2R+13 and the minimum block length is 2R+13.
- R8: When `lat_sel_b` was high at reset, whatever `lat_sel_a` was, `latency_o` = floor(3N/2)+floor(3R/2)+15 and the minimum block length is floor(3R/2)+15.
- R9: The latency selects are sampled only during reset. Changing them afterwards does not alter `latency_o`.
- R10: Once valid, `param_err_o` is high exactly when N is below the minimum block length, or when `fix_en` is high and R < 8. With `fix_en` low, R below 8 alone raises no error.
- R11: For a block whose first symbol is sampled in cycle s, `out_ready_o` is high in cycles s+L to s+L+K-1, where L is the latency. It is low in every cycle that no block covers this way.
- R12: `out_eob_o` is high in cycle s+L+N-1 for each such block, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset; also the first setup phase |
| data_phase | input | 1 | High on data symbols, low on parity symbols of the input stream |
| fix_en | input | 1 | Correction enable; low selects pass-through |
| flag_lim_i | input | 5 | Correction-flag limit, bit 4 most significant, sampled in reset |
| stat_sel_i | input | 1 | Status-byte select, sampled in reset |
| lat_sel_a | input | 1 | Latency select A, sampled in reset |
| lat_sel_b | input | 1 | Latency select B (dominant), sampled in reset |
| k_o | output | 8 | Learned data symbol count |
| r_o | output | 8 | Learned parity symbol count |
| n_o | output | 9 | Learned block length K+R |
| flag_lim_o | output | 5 | Captured correction-flag limit |
| stat_sel_o | output | 1 | Captured status-byte select |
| latency_o | output | 12 | Decode latency in symbol clocks |
| params_valid_o | output | 1 | K, R and N have been learned |
| param_err_o | output | 1 | Learned code unusable in the selected mode |
| blk_start_o | output | 1 | Input-side block start strobe |
| par_start_o | output | 1 | Input-side parity start strobe |
| out_ready_o | output | 1 | Output side is on a data symbol |
| out_eob_o | output | 1 | Output side is on the last symbol of a block |

## Verification
A miscounted K or R shows on the parameter ports one cycle after the second block begins. It also shifts every later ready window and end-of-block pulse. A wrong latency term, or a lost or stale entry in the pending-block queue, first appears when the earliest block should emerge, L cycles after it entered. It then repeats on every later block. For this reason the bench compares both output strobes in every cycle against an arithmetic model built from the recorded input start cycles. Wrong edge detection shows on the strobes in the very next cycle.

// File: rtl/rsd_pkg.sv
// Shared types and constants for the decoder timing controller.
package rsd_pkg;
    // Learning phases of the block-length capture.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAR  = 2'd2,
        PH_RUN  = 2'd3
    } learn_st_t;

    // Smallest parity count usable when correction is enabled.
    localparam int unsigned PAR_MIN_FIX = 8;
endpackage

// File: rtl/rsd_param_learn.sv
// Learns K and R from the first framed block after reset and produces
// input-side edge strobes. Assumes data_phase is low during reset and
// that every block carries at least one data and one parity symbol.
module rsd_param_learn
    import rsd_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int N_W  = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_phase,
    output logic             rise_o,
    output logic [CNT_W-1:0] k_o,
    output logic [CNT_W-1:0] r_o,
    output logic [N_W-1:0]   n_o,
    output logic             valid_o,
    output logic             blk_start_o,
    output logic             par_start_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    learn_st_t        st_q;
    logic             dp_q;
    logic             fall;
    logic [CNT_W-1:0] kc_q;
    logic [CNT_W-1:0] rc_q;

    assign rise_o = data_phase & ~dp_q;
    assign fall   = ~data_phase & dp_q;

    // Previous data_phase sample and registered edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q        <= 1'b0;
            blk_start_o <= 1'b0;
            par_start_o <= 1'b0;
        end else begin
            dp_q        <= data_phase;
            blk_start_o <= rise_o;
            par_start_o <= fall;
        end
    end

    // Phase-two learning: count data and parity cycles, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= PH_IDLE;
            kc_q    <= '0;
            rc_q    <= '0;
            k_o     <= '0;
            r_o     <= '0;
            n_o     <= '0;
            valid_o <= 1'b0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    if (rise_o) begin
                        kc_q <= CNT_W'(1);
                        st_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (data_phase) begin
                        if (kc_q != CNT_MAX) kc_q <= kc_q + CNT_W'(1);
                    end else begin
                        rc_q <= CNT_W'(1);
                        st_q <= PH_PAR;
                    end
                end
                PH_PAR: begin
                    if (!data_phase) begin
                        if (rc_q != CNT_MAX) rc_q <= rc_q + CNT_W'(1);
                    end else begin
                        k_o     <= kc_q;
                        r_o     <= rc_q;
                        n_o     <= {1'b0, kc_q} + {1'b0, rc_q};
                        valid_o <= 1'b1;
                        st_q    <= PH_RUN;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rsd_lat_calc.sv
// Combinational latency and minimum-length evaluation for the three
// latency modes. Select B dominates select A. Halved terms round down
// individually.
module rsd_lat_calc
    import rsd_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int N_W  = CNT_W + 1,
    localparam int LAT_W = N_W + 3
) (
    input  logic [N_W-1:0]   n_i,
    input  logic [CNT_W-1:0] r_i,
    input  logic             sel_a,
    input  logic             sel_b,
    output logic [LAT_W-1:0] lat_o,
    output logic             short_o,
    output logic             par_low_o
);
    logic [LAT_W-1:0] nx;
    logic [LAT_W-1:0] rx;
    logic [LAT_W-1:0] n3h;
    logic [LAT_W-1:0] r3h;
    logic [LAT_W-1:0] lim;

    assign nx = LAT_W'(n_i);
    assign rx = LAT_W'(r_i);

    // Closed-form latency and minimum block length per mode.
    always_comb begin
        n3h = (nx * LAT_W'(3)) >> 1;
        r3h = (rx * LAT_W'(3)) >> 1;
        if (sel_b) begin
            lat_o = n3h + r3h + LAT_W'(15);
            lim   = r3h + LAT_W'(15);
        end else if (sel_a) begin
            lat_o = (nx << 1) + (rx << 1) + LAT_W'(13);
            lim   = (rx << 1) + LAT_W'(13);
        end else begin
            lat_o = (nx << 1) + rx * LAT_W'(5) + LAT_W'(33);
            lim   = rx * LAT_W'(5) + LAT_W'(15);
        end
    end

    assign short_o   = nx < lim;
    assign par_low_o = rx < LAT_W'(PAR_MIN_FIX);
endmodule

// File: rtl/rsd_out_sched.sv
// Output-side scheduler: time-stamps each input block start in a small
// queue and replays it when its age reaches the latency. It then walks
// N output positions and marks data and last symbols. Assumes blocks
// in flight never exceed DEPTH (a power of two) and latency exceeds N+2.
module rsd_out_sched #(
    parameter int N_W   = 9,
    parameter int LAT_W = 12,
    parameter int DEPTH = 8,
    localparam int TS_W  = LAT_W + 1,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             lat_ok_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic [N_W-1:0]   k_i,
    input  logic [N_W-1:0]   n_i,
    output logic             ready_o,
    output logic             eob_o
);
    logic [TS_W-1:0]  ts_q;
    logic [TS_W-1:0]  stamp_mem [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_q;
    logic [PTR_W:0]   cnt_q;
    logic [TS_W-1:0]  age;
    logic [TS_W-1:0]  lat_m1;
    logic             have;
    logic             start;
    logic             stale;
    logic             pop;
    logic             do_push;
    logic             act_q;
    logic             act_d;
    logic [N_W-1:0]   pos_q;
    logic [N_W-1:0]   pos_d;

    assign have    = cnt_q != '0;
    assign age     = ts_q - stamp_mem[rp_q];
    assign lat_m1  = TS_W'(lat_i) - TS_W'(1);
    assign start   = lat_ok_i && have && (age == lat_m1);
    assign stale   = lat_ok_i && have && (age > lat_m1);
    assign pop     = start | stale;
    assign do_push = push_i && ((cnt_q != (PTR_W+1)'(DEPTH)) || pop);

    // Free-running time stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + TS_W'(1);
    end

    // Stamp storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) stamp_mem[wp_q] <= ts_q;
    end

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + PTR_W'(1);
            if (pop)     rp_q <= rp_q + PTR_W'(1);
            unique case ({do_push, pop})
                2'b10:   cnt_q <= cnt_q + (PTR_W+1)'(1);
                2'b01:   cnt_q <= cnt_q - (PTR_W+1)'(1);
                default: ;
            endcase
        end
    end

    // Next output position within the block being replayed.
    always_comb begin
        act_d = 1'b0;
        pos_d = pos_q;
        if (start) begin
            act_d = 1'b1;
            pos_d = '0;
        end else if (act_q && (pos_q != n_i - N_W'(1))) begin
            act_d = 1'b1;
            pos_d = pos_q + N_W'(1);
        end
    end

    // Registered output position and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            pos_q   <= '0;
            ready_o <= 1'b0;
            eob_o   <= 1'b0;
        end else begin
            act_q   <= act_d;
            pos_q   <= pos_d;
            ready_o <= act_d && (pos_d < k_i);
            eob_o   <= act_d && (pos_d == n_i - N_W'(1));
        end
    end
endmodule

// File: rtl/rsd_timing_ctrl.sv
// Top of the decoder timing controller. Captures setup inputs during
// reset, learns the block shape, registers latency and parameter error,
// and schedules output-side strobes. Assumes the setup inputs are held
// through the reset interval and data_phase stays low through reset and
// the two cycles after it.
module rsd_timing_ctrl #(
    parameter int CNT_W = 8,
    parameter int LIM_W = 5,
    parameter int DEPTH = 8,
    localparam int N_W   = CNT_W + 1,
    localparam int LAT_W = N_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_phase,
    input  logic             fix_en,
    input  logic [LIM_W-1:0] flag_lim_i,
    input  logic             stat_sel_i,
    input  logic             lat_sel_a,
    input  logic             lat_sel_b,
    output logic [CNT_W-1:0] k_o,
    output logic [CNT_W-1:0] r_o,
    output logic [N_W-1:0]   n_o,
    output logic [LIM_W-1:0] flag_lim_o,
    output logic             stat_sel_o,
    output logic [LAT_W-1:0] latency_o,
    output logic             params_valid_o,
    output logic             param_err_o,
    output logic             blk_start_o,
    output logic             par_start_o,
    output logic             out_ready_o,
    output logic             out_eob_o
);
    logic             sel_a_q;
    logic             sel_b_q;
    logic             rise;
    logic [LAT_W-1:0] lat_c;
    logic             short_c;
    logic             par_low_c;
    logic             lat_ok_q;

    // Setup capture: follows the inputs while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_lim_o <= flag_lim_i;
            stat_sel_o <= stat_sel_i;
            sel_a_q    <= lat_sel_a;
            sel_b_q    <= lat_sel_b;
        end
    end

    rsd_param_learn #(.CNT_W(CNT_W)) u_learn (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_phase  (data_phase),
        .rise_o      (rise),
        .k_o         (k_o),
        .r_o         (r_o),
        .n_o         (n_o),
        .valid_o     (params_valid_o),
        .blk_start_o (blk_start_o),
        .par_start_o (par_start_o)
    );

    rsd_lat_calc #(.CNT_W(CNT_W)) u_lat (
        .n_i       (n_o),
        .r_i       (r_o),
        .sel_a     (sel_a_q),
        .sel_b     (sel_b_q),
        .lat_o     (lat_c),
        .short_o   (short_c),
        .par_low_o (par_low_c)
    );

    // Registered latency, its qualifier and the parameter-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latency_o   <= '0;
            lat_ok_q    <= 1'b0;
            param_err_o <= 1'b0;
        end else begin
            latency_o   <= params_valid_o ? lat_c : '0;
            lat_ok_q    <= params_valid_o;
            param_err_o <= params_valid_o && (short_c || (fix_en && par_low_c));
        end
    end

    rsd_out_sched #(.N_W(N_W), .LAT_W(LAT_W), .DEPTH(DEPTH)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (rise),
        .lat_ok_i (lat_ok_q),
        .lat_i    (latency_o),
        .k_i      ({1'b0, k_o}),
        .n_i      (n_o),
        .ready_o  (out_ready_o),
        .eob_o    (out_eob_o)
    );
endmodule

// File: rtl/rsd_timing_chk.sv
// Property checker for the decoder timing controller, bound to the top.
module rsd_timing_chk #(
    parameter int CNT_W = 8,
    parameter int LIM_W = 5,
    localparam int N_W   = CNT_W + 1,
    localparam int LAT_W = N_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_phase,
    input logic [CNT_W-1:0] k_o,
    input logic [CNT_W-1:0] r_o,
    input logic [N_W-1:0]   n_o,
    input logic [LIM_W-1:0] flag_lim_o,
    input logic             stat_sel_o,
    input logic [LAT_W-1:0] latency_o,
    input logic             params_valid_o,
    input logic             blk_start_o,
    input logic             par_start_o,
    input logic             out_ready_o,
    input logic             out_eob_o
);
    logic dp_prev;

    // Independent copy of the previous data_phase sample.
    always_ff @(posedge clk) begin
        if (!rst_n) dp_prev <= 1'b0;
        else        dp_prev <= data_phase;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !params_valid_o && !blk_start_o && !par_start_o
                         && !out_ready_o && !out_eob_o && latency_o == '0);

    a_r2_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(flag_lim_o) && $stable(stat_sel_o));

    a_r3_n_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
        params_valid_o |-> (n_o == N_W'(k_o) + N_W'(r_o)) && k_o != '0 && r_o != '0);

    a_r4_params_hold: assert property (@(posedge clk) disable iff (!rst_n)
        params_valid_o |=> params_valid_o && $stable(k_o) && $stable(r_o) && $stable(n_o));

    a_r5_blk_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !dp_prev) |=> blk_start_o);

    a_r5_par_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_phase && dp_prev) |=> par_start_o);

    a_r11_no_output_unlearned: assert property (@(posedge clk) disable iff (!rst_n)
        !params_valid_o |-> !out_ready_o && !out_eob_o);

    a_r12_eob_on_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob_o |-> !out_ready_o);
endmodule

bind rsd_timing_ctrl rsd_timing_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (.*);

// File: tb/tb_rsd_timing_ctrl.sv
`timescale 1ns/1ps
module tb_rsd_timing_ctrl;
    localparam int CNT_W = 8;
    localparam int N_W   = CNT_W + 1;
    localparam int LAT_W = N_W + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_phase = 1'b0;
    logic             fix_en = 1'b1;
    logic [4:0]       flag_lim_i = '0;
    logic             stat_sel_i = 1'b0;
    logic             lat_sel_a = 1'b0;
    logic             lat_sel_b = 1'b0;
    logic [CNT_W-1:0] k_o;
    logic [CNT_W-1:0] r_o;
    logic [N_W-1:0]   n_o;
    logic [4:0]       flag_lim_o;
    logic             stat_sel_o;
    logic [LAT_W-1:0] latency_o;
    logic             params_valid_o;
    logic             param_err_o;
    logic             blk_start_o;
    logic             par_start_o;
    logic             out_ready_o;
    logic             out_eob_o;

    always #4 clk = ~clk;

    rsd_timing_ctrl #(.CNT_W(CNT_W)) dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int starts [64];
    int nst = 0;
    int e_k = 0, e_n = 0, e_l = 0;
    bit mon_on = 1'b0;
    bit dp_prev_tb = 1'b0;
    bit exp_blk = 1'b0, exp_par = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_lat(int n, int r, bit a, bit b);
        if (b)      return (3*n)/2 + (3*r)/2 + 15;
        else if (a) return 2*n + 2*r + 13;
        else        return 2*n + 5*r + 33;
    endfunction

    function automatic int exp_min(int r, bit a, bit b);
        if (b)      return (3*r)/2 + 15;
        else if (a) return 2*r + 13;
        else        return 5*r + 15;
    endfunction

    // Edge model and block-start log, updated at each sampling edge.
    always @(posedge clk) begin
        exp_blk = rst_n && data_phase && !dp_prev_tb;
        exp_par = rst_n && !data_phase && dp_prev_tb;
        if (exp_blk && nst < 64) begin
            starts[nst] = cyc;
            nst++;
        end
        dp_prev_tb = rst_n ? data_phase : 1'b0;
        cyc++;
    end

    // Per-cycle comparison of strobes against the arithmetic model (R5, R11, R12).
    always @(negedge clk) begin
        if (mon_on) begin
            bit er, ee;
            er = 1'b0;
            ee = 1'b0;
            for (int i = 0; i < nst; i++) begin
                int off;
                off = cyc - starts[i] - e_l;
                if (off >= 0 && off < e_k) er = 1'b1;
                if (off == e_n - 1)        ee = 1'b1;
            end
            chk(out_ready_o == er, "R11 out_ready", out_ready_o, er);
            chk(out_eob_o == ee, "R12 out_eob", out_eob_o, ee);
            chk(blk_start_o == exp_blk, "R5 blk_start", blk_start_o, exp_blk);
            chk(par_start_o == exp_par, "R5 par_start", par_start_o, exp_par);
        end
    end

    task automatic run_cfg(input int k, input int r, input bit a, input bit b,
                           input bit fix, input int nblk, input int stretch);
        int n, lat, lim;
        logic [4:0] lim_v;
        bit st_v;
        string lreq;
        n     = k + r;
        lat   = exp_lat(n, r, a, b);
        lim   = exp_min(r, a, b);
        lim_v = 5'((k * 7 + r) % 32);
        st_v  = k[0];
        lreq  = b ? "R8 latency" : (a ? "R7 latency" : "R6 latency");
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; data_phase = 1'b0; fix_en = fix;
        flag_lim_i = lim_v; stat_sel_i = st_v; lat_sel_a = a; lat_sel_b = b;
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk(params_valid_o == 1'b0 && out_ready_o == 1'b0 && blk_start_o == 1'b0,
            "R1 reset outputs", {params_valid_o, out_ready_o, blk_start_o}, 0);
        chk(latency_o == '0 && k_o == '0 && param_err_o == 1'b0,
            "R1 reset params", int'(latency_o), 0);
        rst_n = 1'b1;
        nst = 0; e_k = k; e_n = n; e_l = lat;
        @(negedge clk);
        mon_on = 1'b1;
        chk(params_valid_o == 1'b0 && n_o == '0, "R1 first cycle", params_valid_o, 0);
        // R2 and R9: move setup inputs after reset
        flag_lim_i = ~lim_v; stat_sel_i = ~st_v; lat_sel_a = ~a; lat_sel_b = ~b;
        @(negedge clk);
        for (int bi = 0; bi < nblk; bi++) begin
            data_phase = 1'b1;
            repeat (k + ((bi == 2) ? stretch : 0)) @(negedge clk);
            data_phase = 1'b0;
            repeat (r) @(negedge clk);
        end
        repeat (lat + n + 8) @(negedge clk);
        chk(int'(k_o) == k, "R3 K", k_o, k);
        chk(int'(r_o) == r, "R3 R", r_o, r);
        chk(int'(n_o) == n, "R4 N held", n_o, n);
        chk(params_valid_o == 1'b1, "R3 valid", params_valid_o, 1);
        chk(int'(latency_o) == lat, lreq, latency_o, lat);
        chk(int'(latency_o) == lat, "R9 latched selects", latency_o, lat);
        chk(flag_lim_o == lim_v, "R2 limit", flag_lim_o, lim_v);
        chk(stat_sel_o == st_v, "R2 status", stat_sel_o, st_v);
        chk(param_err_o == ((n < lim) || (fix && r < 8)), "R10 error", param_err_o,
            (n < lim) || (fix && r < 8));
        fix_en = ~fix;
        repeat (2) @(negedge clk);
        chk(param_err_o == ((n < lim) || (!fix && r < 8)), "R10 error after fix toggle",
            param_err_o, (n < lim) || (!fix && r < 8));
        mon_on = 1'b0;
    endtask

    initial begin
        // Sweep: every select combination, two parity counts, several data counts.
        for (int m = 0; m < 4; m++) begin
            for (int ri = 0; ri < 2; ri++) begin
                for (int k = 12; k <= 36; k += 8) begin
                    run_cfg(k, (ri == 0) ? 8 : 11, m[0], m[1], 1'b1, 4, 3);
                end
            end
        end
        // Pass-through with few parity symbols (R10) and floor rounding (R8).
        run_cfg(20, 4, 1'b0, 1'b1, 1'b0, 3, 0);
        run_cfg(21, 9, 1'b1, 1'b1, 1'b1, 3, 5);
        // Short block in the slowest mode (R6, R10).
        run_cfg(40, 8, 1'b0, 1'b0, 1'b1, 3, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule